// File: doc/BRIEF.md
# Buck Converter Operating-Mode Controller

This block is the digital supervisor that picks the operating mode of a buck converter. There are three modes: fixed-frequency PWM, a fast pulse-frequency mode, and a light-load pulse-frequency mode. It runs on the switching clock. Its inputs are comparator flags that are already synchronous to that clock: output inside its regulation window, output below the low-voltage threshold, inductor valley current at zero, and inductor current below the power-save threshold.

While the forced-PWM pin is low, the block moves between PWM and one of the two power-save modes as the load changes. A configuration bit chooses which power-save mode is used. The fast mode is entered only after a qualification run of consecutive clocks. The light-load mode is entered as soon as the inductor current is low. In either power-save mode the block raises the setpoint-select output, so the analog loop lifts its target by about 1%. In the light-load mode the block also stops the oscillator, which restarts only when the output drops low enough to need switching pulses. A low output returns the block to PWM, and the forced-PWM pin always wins.

Top module: `buck_mode_ctrl`

## Requirements
- R1: During and directly after reset, `mode` is PWM (2'b00), `osc_en` is 1 and `setpoint_raise` is 0.
- R2: With `ps_light_sel`=0, `force_pwm`=0 and `out_below_low`=0, the block moves from PWM to fast PFM (`mode`=2'b01) on the clock edge at which `out_in_reg` and `valley_zero` have both been 1 for `QUAL_CYCLES` (default 3) consecutive sampled edges.
- R3: Any sampled edge with `out_in_reg` or `valley_zero` at 0 restarts the qualification, so a full fresh run of `QUAL_CYCLES` edges is needed again.
- R4: With `ps_light_sel`=1, a PWM-mode edge that samples `il_below_ps`=1 (with `force_pwm`=0 and `out_below_low`=0) moves the block to light-load PFM (`mode`=2'b10). The valley/regulation qualification never causes an entry in this case. With `ps_light_sel`=0, `il_below_ps` has no effect.
- R5: An edge that samples `out_below_low`=1 leaves the block in PWM, or returns it there from either power-save mode. It also blocks any power-save entry at that edge.
- R6: An edge that samples `force_pwm`=1 leaves the block in PWM whatever the other inputs are. While the pin stays high no entry happens, and the qualification restarts from zero once it is released.
- R7: `setpoint_raise` is 1 exactly while `mode` is a power-save mode (2'b01 or 2'b10).
- R8: `osc_en` is 1 in PWM and fast PFM. In light-load PFM it follows `out_below_low` within the same cycle, so it is 0 while the output is above the low threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_pwm | input | 1 | Hold the converter in PWM |
| ps_light_sel | input | 1 | Power-save flavour: 0 fast PFM, 1 light-load PFM |
| out_in_reg | input | 1 | Output voltage inside its regulation window |
| out_below_low | input | 1 | Output voltage below the low threshold |
| valley_zero | input | 1 | Inductor valley current reached zero |
| il_below_ps | input | 1 | Inductor current below the power-save threshold |
| mode | output | 2 | 00 PWM, 01 fast PFM, 10 light-load PFM |
| osc_en | output | 1 | Oscillator enable |
| setpoint_raise | output | 1 | Select the raised regulation target |

## Verification
The bench uses the default `QUAL_CYCLES` of 3, so a qualifying run, a run broken after two edges and a rerun all fit in a handful of cycles. At this depth the boundary of R2 and R3 is exercised exactly: two clean edges must not enter fast PFM and the third must. The short window also leaves room to visit both power-save flavours, the forced-PWM pin in every mode, and the same-cycle oscillator wake in light-load mode.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [1:0] {
    MODE_PWM   = 2'b00,
    MODE_FAST  = 2'b01,
    MODE_LIGHT = 2'b10
  } lmc_mode_e;
endpackage

// File: rtl/lmc_qualifier.sv
// Counts consecutive sampled edges on which cond holds; saturates.
module lmc_qualifier #(
  parameter int QUAL_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cond,
  output logic qualified
);
  localparam int CNT_W = (QUAL_CYCLES < 2) ? 1 : $clog2(QUAL_CYCLES);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (clear || !cond) begin
      run_q <= '0;
    end else if (run_q < LIM) begin
      run_q <= run_q + 1'b1;
    end
  end

  // This edge is the QUAL_CYCLES-th consecutive one with cond true.
  assign qualified = cond && !clear && (run_q >= LIM);
endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
  import lmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      force_pwm,
  input  logic      below_low,
  input  logic      fast_ok,
  input  logic      light_ok,
  input  logic      light_sel,
  output lmc_mode_e mode_q
);
  lmc_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (force_pwm || below_low) begin
      mode_d = MODE_PWM;
    end else begin
      case (mode_q)
        MODE_PWM: begin
          if (light_sel && light_ok)       mode_d = MODE_LIGHT;
          else if (!light_sel && fast_ok)  mode_d = MODE_FAST;
        end
        MODE_FAST, MODE_LIGHT: mode_d = mode_q;
        default: mode_d = MODE_PWM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_PWM;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/lmc_out_decode.sv
module lmc_out_decode
  import lmc_pkg::*;
(
  input  lmc_mode_e mode_q,
  input  logic      below_low,
  output logic      osc_en,
  output logic      setpoint_raise
);
  always_comb begin
    osc_en         = 1'b1;
    setpoint_raise = 1'b0;
    case (mode_q)
      MODE_FAST: setpoint_raise = 1'b1;
      MODE_LIGHT: begin
        setpoint_raise = 1'b1;
        osc_en         = below_low;  // wake only when a pulse is needed
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int QUAL_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_pwm,
  input  logic       ps_light_sel,
  input  logic       out_in_reg,
  input  logic       out_below_low,
  input  logic       valley_zero,
  input  logic       il_below_ps,
  output logic [1:0] mode,
  output logic       osc_en,
  output logic       setpoint_raise
);
  lmc_mode_e mode_q;
  logic      fast_ok;
  logic      qual_clear;

  assign qual_clear = force_pwm || (mode_q != MODE_PWM);

  lmc_qualifier #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (qual_clear),
    .cond      (out_in_reg && valley_zero),
    .qualified (fast_ok)
  );

  lmc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .force_pwm (force_pwm),
    .below_low (out_below_low),
    .fast_ok   (fast_ok),
    .light_ok  (il_below_ps),
    .light_sel (ps_light_sel),
    .mode_q    (mode_q)
  );

  lmc_out_decode u_dec (
    .mode_q         (mode_q),
    .below_low      (out_below_low),
    .osc_en         (osc_en),
    .setpoint_raise (setpoint_raise)
  );

  assign mode = mode_q;
endmodule

// File: rtl/lmc_checker.sv
module lmc_checker #(
  parameter int QUAL_CYCLES = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       force_pwm,
  input logic       out_in_reg,
  input logic       out_below_low,
  input logic       valley_zero,
  input logic [1:0] mode,
  input logic       osc_en,
  input logic       setpoint_raise
);
  localparam int RW = $clog2(QUAL_CYCLES + 1) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!(out_in_reg && valley_zero) || force_pwm) run_q <= '0;
    else if (run_q < RW'(QUAL_CYCLES)) run_q <= run_q + 1'b1;
  end

  AST_RESET_PWM: assert property (@(posedge clk)
    !rst_n |=> (mode == 2'b00 && osc_en && !setpoint_raise)); // R1

  AST_FAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b00) |-> run_q >= RW'(QUAL_CYCLES)); // R2

  AST_LOW_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_below_low |=> mode == 2'b00); // R5

  AST_FORCE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> mode == 2'b00); // R6

  AST_RAISE_IN_PS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |-> setpoint_raise); // R7

  AST_NO_RAISE_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> !setpoint_raise); // R7

  AST_OSC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> osc_en); // R8

  AST_OSC_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && !out_below_low) |-> !osc_en); // R8
endmodule

bind buck_mode_ctrl lmc_checker #(.QUAL_CYCLES(QUAL_CYCLES)) u_lmc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .force_pwm      (force_pwm),
  .out_in_reg     (out_in_reg),
  .out_below_low  (out_below_low),
  .valley_zero    (valley_zero),
  .mode           (mode),
  .osc_en         (osc_en),
  .setpoint_raise (setpoint_raise)
);

// File: tb/test_buck_mode_ctrl.sv
module test_buck_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       force_pwm = 0, ps_light_sel = 0, out_in_reg = 0;
  logic       out_below_low = 0, valley_zero = 0, il_below_ps = 0;
  logic [1:0] mode;
  logic       osc_en, setpoint_raise;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [1:0] m;
    logic       o;
    logic       r;
    string      tag;
  } exp_t;
  exp_t q[$];

  localparam logic [1:0] PWM = 2'b00, FAST = 2'b01, LIGHT = 2'b10;

  always #5 clk = ~clk;

  buck_mode_ctrl #(.QUAL_CYCLES(3)) i_buck_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .force_pwm(force_pwm), .ps_light_sel(ps_light_sel),
    .out_in_reg(out_in_reg), .out_below_low(out_below_low), .valley_zero(valley_zero),
    .il_below_ps(il_below_ps), .mode(mode), .osc_en(osc_en), .setpoint_raise(setpoint_raise)
  );

  task automatic compare(input logic [1:0] em, input logic eo, input logic er, input string tag);
    total++;
    if (mode !== em || osc_en !== eo || setpoint_raise !== er) begin
      bad++;
      $display("FAIL %s: mode=%b osc=%b raise=%b expected mode=%b osc=%b raise=%b",
               tag, mode, osc_en, setpoint_raise, em, eo, er);
    end
  endtask

  // Driver: apply inputs for one cycle and queue the state expected after the edge.
  task automatic step(input logic ir, input logic bl, input logic vz, input logic cl,
                      input logic fp, input logic ps, input logic [1:0] em,
                      input logic eo, input logic er, input string tag);
    exp_t e;
    @(negedge clk);
    out_in_reg = ir; out_below_low = bl; valley_zero = vz;
    il_below_ps = cl; force_pwm = fp; ps_light_sel = ps;
    e.m = em; e.o = eo; e.r = er; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pop one expectation per edge, sample shortly after it.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.m, e.o, e.r, e.tag);
    end
  end

  initial begin : watchdog
    #200us;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare(PWM, 1'b1, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(0,0,0,0,0,0, PWM,1,0, "R1 after release");
    // R2: qualifying run of three edges
    step(1,0,1,0,0,0, PWM,1,0, "R2 edge1");
    step(1,0,1,0,0,0, PWM,1,0, "R2 edge2");
    step(1,0,1,0,0,0, FAST,1,1, "R2 edge3");
    step(1,0,1,0,0,0, FAST,1,1, "R7 hold fast");
    step(0,1,0,0,0,0, PWM,1,0, "R5 exit fast");
    // R3: broken run restarts
    step(1,0,1,0,0,0, PWM,1,0, "R3 a1");
    step(1,0,1,0,0,0, PWM,1,0, "R3 a2");
    step(1,0,0,0,0,0, PWM,1,0, "R3 valley break");
    step(1,0,1,0,0,0, PWM,1,0, "R3 b1");
    step(0,0,1,0,0,0, PWM,1,0, "R3 reg break");
    step(1,0,1,0,0,0, PWM,1,0, "R3 c1");
    step(1,0,1,0,0,0, PWM,1,0, "R3 c2");
    step(1,0,1,0,0,0, FAST,1,1, "R3 c3");
    // R6: force from power-save, then held
    step(1,0,1,0,1,0, PWM,1,0, "R6 force exit");
    step(1,0,1,0,1,0, PWM,1,0, "R6 held1");
    step(1,0,1,0,1,0, PWM,1,0, "R6 held2");
    step(1,0,1,1,1,1, PWM,1,0, "R6 held light sel");
    step(1,0,1,0,0,0, PWM,1,0, "R6 rerun1");
    step(1,0,1,0,0,0, PWM,1,0, "R6 rerun2");
    step(1,0,1,0,0,0, FAST,1,1, "R6 rerun3");
    step(0,1,0,0,0,0, PWM,1,0, "R5 exit again");
    // R4: select bit behaviour
    step(0,0,0,1,0,0, PWM,1,0, "R4 cur_low ignored");
    step(1,0,1,0,0,1, PWM,1,0, "R4 qual1 light sel");
    step(1,0,1,0,0,1, PWM,1,0, "R4 qual2 light sel");
    step(1,0,1,0,0,1, PWM,1,0, "R4 qual3 light sel");
    step(1,0,1,0,0,1, PWM,1,0, "R4 qual4 light sel");
    step(0,1,0,1,0,1, PWM,1,0, "R5 low blocks entry");
    step(0,0,0,1,0,1, LIGHT,0,1, "R4 enter light");
    step(0,0,0,0,0,1, LIGHT,0,1, "R8 osc asleep");
    // R8: same-cycle wake, then R5 exit
    @(negedge clk);
    wait (q.size() == 0);
    out_below_low = 1'b1;
    #1;
    compare(LIGHT, 1'b1, 1'b1, "R8 wake");
    step(0,1,0,0,0,1, PWM,1,0, "R5 exit light");
    step(0,0,0,1,0,1, LIGHT,0,1, "R4 reenter light");
    step(0,0,0,1,1,1, PWM,1,0, "R6 force from light");
    step(0,0,0,0,0,0, PWM,1,0, "R7 pwm no raise");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule